// File: doc/BRIEF.md
# Depth-Cascaded FIFO Expansion Controller

This block builds one deep FIFO out of several identical storage banks that share the write data, read data, write strobe and read strobe. Each bank holds a write token and a read token. The bank that holds the write token is the only one that accepts writes. The bank that holds the read token is the only one that supplies the read word. When a bank writes into its last address, it hands the write token to the next bank in a ring. It signals the hand-off as a one-cycle pulse on its chain output. The read token moves around the ring the same way. The result is a FIFO whose depth is the bank count times the bank depth, with no gap at a bank boundary.

The operating mode is taken from strap inputs while reset is held, and it stays fixed until the next reset. In single-bank mode only the selected starting bank works. That bank offers a half-full indication and a retransmit function, and its chain outputs stay quiet. In cascade mode every bank takes part. Retransmit and half-full are switched off, and the bank flags are merged: the composite full flag requires every bank to be full, and the composite empty flag requires every bank to be empty. All logic uses one clock and a synchronous active-low reset. Read data falls through, so the oldest word is always on the read port whenever the FIFO is not empty.

Top module: `cascade_fifo_ctrl`

## Requirements
- R1: `strap_cascade` and `strap_first` are sampled only on clock edges where `rst_n` is low. Changing them after reset has no effect on the mode, the capacity or the starting bank.
- R2: After reset, `empty`=1, `full`=0, `half_full`=0, and `xo_wr`/`xo_rd` are all zero. `wr_token` and `rd_token` are both the one-hot vector with bit `strap_first` set.
- R3: In cascade mode, the FIFO holds NUM_BANKS*BANK_DEPTH words and returns them in write order across bank boundaries.
- R4: In cascade mode, an accepted write to address BANK_DEPTH-1 of a bank moves the write token to bank (index+1) mod NUM_BANKS. In the cycle after that write, `xo_wr[index]` is 1 for exactly one cycle, and the new bank already accepts writes in that cycle.
- R5: In cascade mode, an accepted read of address BANK_DEPTH-1 moves the read token to the next bank in the same way, with a one-cycle pulse on `xo_rd[index]`.
- R6: Whenever `empty`=0, `rd_data` shows the oldest stored word, taken from the bank that holds the read token.
- R7: `full` is 1 only when every working bank is full. A write while `full`=1 is ignored.
- R8: `empty` is 1 only when every working bank is empty. A read while `empty`=1 is ignored.
- R9: In cascade mode, `retransmit` has no effect, and reads and writes in the same cycle proceed normally.
- R10: `half_full` is 1 only in single-bank mode, and only while the occupancy is greater than BANK_DEPTH/2.
- R11: In single-bank mode only bank `strap_first` works. The capacity is BANK_DEPTH, both token vectors stay one-hot on that bank, and `xo_wr`/`xo_rd` stay zero.
- R12: In single-bank mode, `retransmit` sets the read address to 0 and the occupancy to the number of words written since reset. This is valid while fewer than BANK_DEPTH words have been written since reset. Reads and writes in the same cycle as a retransmit are ignored.
- R13: A read and a write in the same cycle are both accepted when the FIFO is neither full nor empty. At full, the read is accepted and the write is refused. At empty, the write is accepted and the read is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_cascade | input | 1 | Mode strap, sampled during reset: 1 = cascade, 0 = single bank |
| strap_first | input | SEL_W | Index of the starting bank, sampled during reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write word |
| rd_en | input | 1 | Read strobe (takes the word shown on rd_data) |
| rd_data | output | DATA_W | Oldest stored word |
| retransmit | input | 1 | Restart reads at address 0 (single-bank mode only) |
| full | output | 1 | Composite full |
| empty | output | 1 | Composite empty |
| half_full | output | 1 | Occupancy above half (single-bank mode only) |
| wr_token | output | NUM_BANKS | One-hot: bank accepting writes |
| rd_token | output | NUM_BANKS | One-hot: bank supplying reads |
| xo_wr | output | NUM_BANKS | Per-bank write-token pass pulse |
| xo_rd | output | NUM_BANKS | Per-bank read-token pass pulse |

## Verification
All outputs are decoded from registered state, so every result of a strobe applied in one cycle appears just after the next rising edge. This covers flags, read word, token vectors and pass pulses. A pass pulse lasts exactly that one cycle, and the token vector already shows the receiving bank in that cycle. The bench drives each stimulus just after a falling edge and compares all outputs at the following falling edge against a queue-based model. That model computes the expected bank from the running write and read counts. A strap change is applied right after reset is released, so every later check also covers the mode hold.

// File: rtl/cascade_fifo_pkg.sv
// Package: shared types and helpers for the cascaded FIFO controller.
// Assumes: nothing beyond standard SystemVerilog.
package cascade_fifo_pkg;

    // Operating mode captured during reset
    typedef enum logic {
        MODE_SINGLE  = 1'b0,
        MODE_CASCADE = 1'b1
    } fifo_mode_e;

    // Index of the bank that precedes bank i in a ring of n banks
    function automatic int ring_prev(input int i, input int n);
        return (i + n - 1) % n;
    endfunction

endpackage

// File: rtl/cascade_bank.sv
// Module: one storage bank with its write/read pointers, its occupancy
// and its write and read token stages.
// Assumes: BANK_DEPTH >= 2. The chain inputs come from the registered pass
// pulses of the preceding bank. cascade/is_first are stable outside reset.
module cascade_bank #(
    parameter int DATA_W     = 9,
    parameter int BANK_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cascade,
    input  logic              is_first,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              retransmit,
    input  logic              xi_wr,
    input  logic              xi_rd,
    output logic              xo_wr,
    output logic              xo_rd,
    output logic              wr_hold,
    output logic              rd_hold,
    output logic              full,
    output logic              empty,
    output logic              half_full,
    output logic [DATA_W-1:0] rd_word
);
    localparam int ADDR_W = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1;
    localparam int CNT_W  = $clog2(BANK_DEPTH + 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(BANK_DEPTH - 1);
    localparam logic [CNT_W-1:0]  CNT_FULL  = CNT_W'(BANK_DEPTH);
    localparam logic [CNT_W-1:0]  CNT_HALF  = CNT_W'(BANK_DEPTH / 2);

    logic [DATA_W-1:0] mem [BANK_DEPTH];
    logic [ADDR_W-1:0] wp, rp;
    logic [CNT_W-1:0]  count;
    logic              tok_w_q, tok_r_q;
    logic              xo_w_q, xo_r_q;
    logic              rt_go, wr_go, rd_go, wr_pass, rd_pass;

    // Token ownership: in cascade a held token or an incoming pass pulse; single fixes it to the first bank
    always_comb begin
        wr_hold = cascade ? (tok_w_q | xi_wr) : is_first;
        rd_hold = cascade ? (tok_r_q | xi_rd) : is_first;
    end

    // Accept decisions and pass detection for this cycle
    always_comb begin
        full    = (count == CNT_FULL);
        empty   = (count == '0);
        rt_go   = !cascade && is_first && retransmit;
        wr_go   = wr_hold && wr_en && !full && !rt_go;
        rd_go   = rd_hold && rd_en && !empty && !rt_go;
        wr_pass = cascade && wr_go && (wp == LAST_ADDR);
        rd_pass = cascade && rd_go && (rp == LAST_ADDR);
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (rt_go) begin
            rp    <= '0;
            count <= CNT_W'(wp);
        end else begin
            if (wr_go) wp <= (wp == LAST_ADDR) ? '0 : wp + 1'b1;
            if (rd_go) rp <= (rp == LAST_ADDR) ? '0 : rp + 1'b1;
            case ({wr_go, rd_go})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (wr_go) mem[wp] <= wr_data;
    end

    // Token registers and registered pass pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok_w_q <= is_first;
            tok_r_q <= is_first;
            xo_w_q  <= 1'b0;
            xo_r_q  <= 1'b0;
        end else begin
            tok_w_q <= (tok_w_q | xi_wr) & ~wr_pass;
            tok_r_q <= (tok_r_q | xi_rd) & ~rd_pass;
            xo_w_q  <= wr_pass;
            xo_r_q  <= rd_pass;
        end
    end

    // Output drive
    always_comb begin
        xo_wr     = xo_w_q;
        xo_rd     = xo_r_q;
        half_full = !cascade && (count > CNT_HALF);
        rd_word   = mem[rp];
    end

endmodule

// File: rtl/cascade_flag_merge.sv
// Module: merges the per-bank flags into composite flags and selects the
// read word from the bank that holds the read token.
// Assumes: rd_sel is one-hot. In single mode first_oh names the only working bank.
module cascade_flag_merge #(
    parameter int NUM_BANKS = 3,
    parameter int DATA_W    = 9
) (
    input  logic                 cascade,
    input  logic [NUM_BANKS-1:0] first_oh,
    input  logic [NUM_BANKS-1:0] bank_full,
    input  logic [NUM_BANKS-1:0] bank_empty,
    input  logic [NUM_BANKS-1:0] bank_hf,
    input  logic [NUM_BANKS-1:0] rd_sel,
    input  logic [DATA_W-1:0]    words [NUM_BANKS],
    output logic                 full,
    output logic                 empty,
    output logic                 half_full,
    output logic [DATA_W-1:0]    rd_data
);
    // Composite flags: all banks in cascade, the first bank alone otherwise
    always_comb begin
        full      = cascade ? (&bank_full)  : |(bank_full  & first_oh);
        empty     = cascade ? (&bank_empty) : |(bank_empty & first_oh);
        half_full = !cascade && |(bank_hf & first_oh);
    end

    // Read word select: OR of the words masked by the one-hot read owner
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (rd_sel[i]) rd_data = rd_data | words[i];
        end
    end

endmodule

// File: rtl/cascade_fifo_ctrl.sv
// Module: top of the depth-cascaded FIFO. It captures the mode straps during
// reset, builds the ring of banks, wires each bank's pass pulses into the
// next bank, and merges the flags.
// Assumes: NUM_BANKS >= 2, BANK_DEPTH >= 2, strap_first < NUM_BANKS.
module cascade_fifo_ctrl
    import cascade_fifo_pkg::*;
#(
    parameter int NUM_BANKS  = 3,
    parameter int BANK_DEPTH = 8,
    parameter int DATA_W     = 9,
    localparam int SEL_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strap_cascade,
    input  logic [SEL_W-1:0]     strap_first,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_en,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 retransmit,
    output logic                 full,
    output logic                 empty,
    output logic                 half_full,
    output logic [NUM_BANKS-1:0] wr_token,
    output logic [NUM_BANKS-1:0] rd_token,
    output logic [NUM_BANKS-1:0] xo_wr,
    output logic [NUM_BANKS-1:0] xo_rd
);
    fifo_mode_e         mode_q, mode_now;
    logic [SEL_W-1:0]   first_q, first_now;
    logic               casc_now;
    logic [NUM_BANKS-1:0] first_oh;
    logic [NUM_BANKS-1:0] b_full, b_empty, b_hf;
    logic [DATA_W-1:0]    b_word [NUM_BANKS];

    // Strap capture: load while reset is held, hold afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= strap_cascade ? MODE_CASCADE : MODE_SINGLE;
            first_q <= strap_first;
        end
    end

    // Effective mode: live straps during reset so bank resets see them
    always_comb begin
        mode_now  = rst_n ? mode_q : (strap_cascade ? MODE_CASCADE : MODE_SINGLE);
        first_now = rst_n ? first_q : strap_first;
        casc_now  = (mode_now == MODE_CASCADE);
    end

    generate
        for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
            localparam int PREV = ring_prev(i, NUM_BANKS);

            // Starting-bank decode for this ring position
            always_comb first_oh[i] = (first_now == SEL_W'(i));

            cascade_bank #(
                .DATA_W     (DATA_W),
                .BANK_DEPTH (BANK_DEPTH)
            ) u_bank (
                .clk        (clk),
                .rst_n      (rst_n),
                .cascade    (casc_now),
                .is_first   (first_oh[i]),
                .wr_en      (wr_en),
                .wr_data    (wr_data),
                .rd_en      (rd_en),
                .retransmit (retransmit),
                .xi_wr      (xo_wr[PREV]),
                .xi_rd      (xo_rd[PREV]),
                .xo_wr      (xo_wr[i]),
                .xo_rd      (xo_rd[i]),
                .wr_hold    (wr_token[i]),
                .rd_hold    (rd_token[i]),
                .full       (b_full[i]),
                .empty      (b_empty[i]),
                .half_full  (b_hf[i]),
                .rd_word    (b_word[i])
            );
        end
    endgenerate

    cascade_flag_merge #(
        .NUM_BANKS (NUM_BANKS),
        .DATA_W    (DATA_W)
    ) u_merge (
        .cascade    (casc_now),
        .first_oh   (first_oh),
        .bank_full  (b_full),
        .bank_empty (b_empty),
        .bank_hf    (b_hf),
        .rd_sel     (rd_token),
        .words      (b_word),
        .full       (full),
        .empty      (empty),
        .half_full  (half_full),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/cascade_fifo_ctrl_chk.sv
// Module: protocol checker for cascade_fifo_ctrl, attached with bind.
// Assumes: BANK_DEPTH >= 2, so pass pulses cannot repeat on consecutive cycles.
module cascade_fifo_ctrl_chk #(
    parameter int NUM_BANKS = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cascade,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic                 retransmit,
    input logic                 full,
    input logic                 empty,
    input logic                 half_full,
    input logic [NUM_BANKS-1:0] wr_token,
    input logic [NUM_BANKS-1:0] rd_token,
    input logic [NUM_BANKS-1:0] xo_wr,
    input logic [NUM_BANKS-1:0] xo_rd
);
    a_r4_wr_token_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_token) == 1);

    a_r5_rd_token_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd_token) == 1);

    a_r4_xo_wr_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (xo_wr != '0) |=> (xo_wr == '0));

    a_r5_xo_rd_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (xo_rd != '0) |=> (xo_rd == '0));

    a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en && !retransmit) |=> full);

    a_r8_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_en && !retransmit) |=> empty);

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    a_r10_no_half_full_cascade: assert property (@(posedge clk) disable iff (!rst_n)
        cascade |-> !half_full);

    a_r11_quiet_chain_single: assert property (@(posedge clk) disable iff (!rst_n)
        !cascade |-> (xo_wr == '0 && xo_rd == '0));

endmodule

bind cascade_fifo_ctrl cascade_fifo_ctrl_chk #(
    .NUM_BANKS (NUM_BANKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cascade    (casc_now),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .retransmit (retransmit),
    .full       (full),
    .empty      (empty),
    .half_full  (half_full),
    .wr_token   (wr_token),
    .rd_token   (rd_token),
    .xo_wr      (xo_wr),
    .xo_rd      (xo_rd)
);

// File: tb/test_cascade_fifo_ctrl.sv
`timescale 1ns/1ps
module test_cascade_fifo_ctrl;
    localparam int N  = 3;
    localparam int D  = 8;
    localparam int W  = 9;
    localparam int SW = 2;

    // Stimulus table: bit 10 = write, bit 9 = read, bits 8:0 = data
    localparam int NV = 16;
    localparam logic [10:0] VEC [NV] = '{
        {1'b0, 1'b1, 9'h000}, {1'b1, 1'b0, 9'h101}, {1'b1, 1'b0, 9'h0A2}, {1'b1, 1'b1, 9'h1F3},
        {1'b1, 1'b0, 9'h004}, {1'b0, 1'b1, 9'h000}, {1'b1, 1'b0, 9'h155}, {1'b1, 1'b0, 9'h0AA},
        {1'b1, 1'b1, 9'h1C8}, {1'b1, 1'b0, 9'h039}, {1'b1, 1'b0, 9'h1EE}, {1'b0, 1'b1, 9'h000},
        {1'b1, 1'b0, 9'h077}, {1'b1, 1'b1, 9'h100}, {1'b1, 1'b0, 9'h0FF}, {1'b0, 1'b1, 9'h000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strap_cascade = 1'b1;
    logic [SW-1:0] strap_first = '0;
    logic          wr_en = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic          rd_en = 1'b0;
    logic          retransmit = 1'b0;
    logic [W-1:0]  rd_data;
    logic          full, empty, half_full;
    logic [N-1:0]  wr_token, rd_token, xo_wr, xo_rd;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] q[$];
    logic [W-1:0] hist[$];
    int  wcnt, rcnt, first_m, cap;
    logic casc_m;

    always #2.5 clk = ~clk;

    cascade_fifo_ctrl i_cascade_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .strap_cascade(strap_cascade), .strap_first(strap_first),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .retransmit(retransmit), .full(full), .empty(empty), .half_full(half_full),
        .wr_token(wr_token), .rd_token(rd_token), .xo_wr(xo_wr), .xo_rd(xo_rd)
    );

    function automatic logic [N-1:0] oh(input int b);
        return N'(1) << b;
    endfunction

    function automatic int bank_of(input int n);
        return (first_m + (n / D) % N) % N;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(input logic [N-1:0] exw, input logic [N-1:0] exr);
        chk("R7 full", full, q.size() == cap);
        chk("R8 empty", empty, q.size() == 0);
        chk("R10 half_full", half_full, !casc_m && q.size() > D / 2);
        if (q.size() > 0) chk("R6 rd_data", rd_data, q[0]);
        chk("R4 wr_token", wr_token, casc_m ? oh(bank_of(wcnt)) : oh(first_m));
        chk("R5 rd_token", rd_token, casc_m ? oh(bank_of(rcnt)) : oh(first_m));
        chk("R4 xo_wr", xo_wr, exw);
        chk("R5 xo_rd", xo_rd, exr);
    endtask

    // One cycle: drive after a falling edge, model the edge, check at the next falling edge
    task automatic step(input logic w, input logic r, input logic [W-1:0] d, input logic rt);
        logic [N-1:0] exw, exr;
        int sz;
        wr_en = w; rd_en = r; wr_data = d; retransmit = rt;
        @(posedge clk);
        exw = '0; exr = '0;
        sz = q.size();
        if (rt && !casc_m) begin
            q = hist;   // R12 model
        end else begin
            if (r && sz > 0) begin
                if (casc_m && (rcnt % D) == D - 1) exr = oh(bank_of(rcnt));
                void'(q.pop_front());
                rcnt++;
            end
            if (w && sz < cap) begin
                if (casc_m && (wcnt % D) == D - 1) exw = oh(bank_of(wcnt));
                q.push_back(d);
                if (!casc_m) hist.push_back(d);
                wcnt++;
            end
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; retransmit = 1'b0;
        check_outputs(exw, exr);
    endtask

    task automatic do_reset(input logic casc, input int first);
        @(negedge clk);
        rst_n = 1'b0; strap_cascade = casc; strap_first = SW'(first);
        wr_en = 1'b0; rd_en = 1'b0; retransmit = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: flip the straps right after reset; later checks expect the captured mode
        strap_cascade = !casc;
        strap_first = SW'((first + 1) % N);
        casc_m = casc; first_m = first; cap = casc ? N * D : D;
        q.delete(); hist.delete(); wcnt = 0; rcnt = 0;
        chk("R2 reset tokens", {wr_token, rd_token}, {oh(first), oh(first)});
        check_outputs('0, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Cascade, start at bank 0: table walk
        do_reset(1'b1, 0);
        for (int k = 0; k < NV; k++) step(VEC[k][10], VEC[k][9], VEC[k][8:0], 1'b0);

        // R3: fill to full capacity across all banks
        for (int k = 0; k < 40 && q.size() < N * D; k++) step(1'b1, 1'b0, W'(k * 37 + 5), 1'b0);
        chk("R3 capacity", full, 1'b1);
        chk("R3 occupancy", q.size(), N * D);
        // R7: write at full ignored; R13: read+write at full reads only
        step(1'b1, 1'b0, 9'h1AB, 1'b0);
        step(1'b1, 1'b1, 9'h1CD, 1'b0);
        // R9: retransmit ignored in cascade
        step(1'b0, 1'b0, '0, 1'b1);
        chk("R9 retransmit ignored", rd_data, q[0]);
        step(1'b0, 1'b1, '0, 1'b1);
        // drain; R8 read on empty ignored
        for (int k = 0; k < 40 && q.size() > 0; k++) step(1'b0, 1'b1, '0, 1'b0);
        step(1'b0, 1'b1, '0, 1'b0);
        chk("R8 empty after drain", empty, 1'b1);
        // R13: simultaneous read/write keeps occupancy
        step(1'b1, 1'b0, 9'h011, 1'b0);
        for (int k = 0; k < 6; k++) step(1'b1, 1'b1, W'(k + 9'h020), 1'b0);
        chk("R13 simultaneous", q.size(), 1);

        // Cascade starting at bank 2: token wraps to bank 0
        do_reset(1'b1, 2);
        for (int k = 0; k < 9; k++) step(1'b1, 1'b0, W'(k * 3 + 1), 1'b0);
        chk("R4 ring wrap", wr_token, 3'b001);
        for (int k = 0; k < 9; k++) step(1'b0, 1'b1, '0, 1'b0);
        chk("R5 ring wrap", rd_token, 3'b001);

        // Single mode on bank 0; straps flip to cascade after reset
        do_reset(1'b0, 0);
        for (int k = 0; k < 10; k++) step(1'b1, 1'b0, W'(k + 9'h050), 1'b0);
        chk("R1 mode held", full, 1'b1);
        chk("R11 single capacity", q.size(), D);
        chk("R11 no chain pulse", {xo_wr, xo_rd}, '0);
        for (int k = 0; k < 4; k++) step(1'b0, 1'b1, '0, 1'b0);
        chk("R10 half_full clears", half_full, 1'b0);

        // Single mode on bank 1: retransmit
        do_reset(1'b0, 1);
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0, W'(k * 11 + 9'h100), 1'b0);
        step(1'b0, 1'b1, '0, 1'b0);
        step(1'b0, 1'b1, '0, 1'b0);
        step(1'b1, 1'b1, 9'h0EE, 1'b1);
        chk("R12 restart word", rd_data, hist[0]);
        chk("R12 occupancy", half_full, 1'b1);
        for (int k = 0; k < 5; k++) step(1'b0, 1'b1, '0, 1'b0);
        chk("R12 empty after replay", empty, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule